// File: doc/BRIEF.md
# Power-Up Reset and Boot Sequencer

This block owns the reset of a small processor core. A power-on indication (`por_n`) clears every flop at once. After it is released, the block keeps the core in reset for a fixed lock window, counted in input-clock cycles and converted to internal-clock cycles, so that the clock multiplier can settle. The raw board reset (`rst_raw_n`) passes through a two-flop synchroniser. Once the lock window has been served, that reset only needs to meet a minimum pulse width. Shorter dips are treated as glitches and discarded.

While the core is held in reset, the block asserts three clear strobes: stack pointers to empty, all interrupts masked, and the mode/status register cleared. When reset lifts, the sequencer looks at the bus-request input and the boot strap. A pending bus request parks the sequencer in a hold state. With no request and the strap set, it starts the boot loader and waits for `boot_done`. With the strap clear, it goes straight to instruction fetch from address zero.

The block also registers the enable for the clock output. That enable stays off during the lock window and whenever the disable control bit is set.

Top module: `rst_boot_seq`

## Requirements
- R1: After `por_n` rises, `core_rst_n` stays low for at least LOCK_IN_CYCLES*CLK_RATIO (default 4000) internal clock cycles, even when `rst_raw_n` is high the whole time.
- R2: After the lock window, holding `rst_raw_n` low for MIN_PULSE (default 8) or more cycles drives `core_rst_n` low, and it stays low while `rst_raw_n` is low. Once `rst_raw_n` returns high, `core_rst_n` rises within 5 cycles, with no new lock wait.
- R3: A low pulse on `rst_raw_n` shorter than MIN_PULSE cycles leaves `core_rst_n` and `fetch_en` unchanged.
- R4: While `core_rst_n` is low, `stack_rst`, `int_mask_all` and `status_clr` are all 1. While `core_rst_n` is high, all three are 0.
- R5: When reset lifts with `bus_req`=0 and `boot_strap`=1, `boot_start` goes high and stays high until `boot_done` is seen. The sequencer then enters the run state.
- R6: When reset lifts with `bus_req`=0 and `boot_strap`=0, `fetch_en` goes high directly and `boot_start` never rises.
- R7: If `bus_req` is 1 when reset lifts, `core_rst_n` goes high while `boot_start` and `fetch_en` stay 0 until `bus_req` drops. The boot choice is then made from `boot_strap` as it is at that moment.
- R8: `fetch_addr` is all ones from power-on and during any reset. While `fetch_en` is high, `fetch_addr` is START_ADDR (default 0).
- R9: `clkout_en` follows the inverse of `clkout_dis` with one cycle of delay. It is forced to 0 throughout the lock window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal instruction clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous clear |
| rst_raw_n | input | 1 | Raw board reset, active low, asynchronous to clk |
| bus_req | input | 1 | External bus request pending |
| boot_strap | input | 1 | Boot-from-memory strap |
| boot_done | input | 1 | Boot loader has finished |
| clkout_dis | input | 1 | Control bit that turns the clock output off |
| core_rst_n | output | 1 | Core reset, active low |
| stack_rst | output | 1 | Force all stack pointers to empty |
| int_mask_all | output | 1 | Mask every interrupt |
| status_clr | output | 1 | Clear the mode/status register |
| boot_start | output | 1 | Boot loader run request |
| fetch_en | output | 1 | Core may fetch instructions |
| fetch_addr | output | ADDR_W | First fetch address |
| clkout_en | output | 1 | Clock output enable |

## Verification
The hardest condition to reach is a bus request that is still pending at the exact moment reset lifts, combined with a strap that changes while the sequencer is parked. The bench holds `bus_req` high through a long warm reset and watches the hold state cycle by cycle. It then flips `boot_strap` and drops the request in the same cycle, which proves the boot decision is taken at the drop and not at reset release.

A second case that is hard to hit is a reset dip just below the minimum width. The bench drives one synchronously so that its length after the synchroniser is known exactly.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [2:0] {
    ST_LOCK  = 3'd0,
    ST_RESET = 3'd1,
    ST_HOLD  = 3'd2,
    ST_BOOT  = 3'd3,
    ST_RUN   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/rbs_sync.sv
module rbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh[0] <= 1'b0;
        else         sh[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh[i] <= 1'b0;
        else         sh[i] <= sh[i-1];
      end
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rbs_pulse_filter.sv
module rbs_pulse_filter #(
  parameter int MIN_PULSE = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_s,
  output logic hit
);
  localparam int CW = (MIN_PULSE < 2) ? 1 : $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // counts consecutive low cycles of the synchronised reset, saturating
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (rst_s) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit = !rst_s && (cnt_q == LAST);
endmodule

// File: rtl/rbs_lock_cnt.sv
module rbs_lock_cnt #(
  parameter int TICKS = 4000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    cnt_en = run && !done;
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rbs_fsm.sv
module rbs_fsm
  import rbs_pkg::*;
#(
  parameter int              ADDR_W     = 14,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              lock_done,
  input  logic              rst_s,
  input  logic              warm_hit,
  input  logic              bus_req,
  input  logic              boot_strap,
  input  logic              boot_done,
  output seq_state_e        state_q,
  output logic [ADDR_W-1:0] fetch_addr
);
  seq_state_e        state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  seq_state_e        release_tgt;

  // where the core goes once reset and any bus request are gone
  assign release_tgt = boot_strap ? ST_BOOT : ST_RUN;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOCK:  if (lock_done) state_d = ST_RESET;
      ST_RESET: if (rst_s)     state_d = bus_req ? ST_HOLD : release_tgt;
      ST_HOLD:  if (!bus_req)  state_d = release_tgt;
      ST_BOOT:  if (boot_done) state_d = ST_RUN;
      ST_RUN:   state_d = ST_RUN;
      default:  state_d = ST_LOCK;
    endcase
    if (state_q != ST_LOCK && state_q != ST_RESET && warm_hit)
      state_d = ST_RESET;
  end

  always_comb begin
    addr_d = addr_q;
    if (state_d == ST_RESET)
      addr_d = '1;
    else if (state_d == ST_RUN && state_q != ST_RUN)
      addr_d = START_ADDR;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_LOCK;
      addr_q  <= '1;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign fetch_addr = addr_q;
endmodule

// File: rtl/rst_boot_seq.sv
module rst_boot_seq
  import rbs_pkg::*;
#(
  parameter int                LOCK_IN_CYCLES = 2000,
  parameter int                CLK_RATIO      = 2,
  parameter int                MIN_PULSE      = 8,
  parameter int                SYNC_STAGES    = 2,
  parameter int                ADDR_W         = 14,
  parameter logic [ADDR_W-1:0] START_ADDR     = '0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_raw_n,
  input  logic              bus_req,
  input  logic              boot_strap,
  input  logic              boot_done,
  input  logic              clkout_dis,
  output logic              core_rst_n,
  output logic              stack_rst,
  output logic              int_mask_all,
  output logic              status_clr,
  output logic              boot_start,
  output logic              fetch_en,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              clkout_en
);
  localparam int LOCK_TICKS = LOCK_IN_CYCLES * CLK_RATIO;

  logic       rst_s;
  logic       warm_hit;
  logic       lock_done;
  logic       in_lock;
  logic       in_rst;
  seq_state_e state_q;
  logic       ck_en_q, ck_en_d;

  rbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .arst_n(por_n),
    .d     (rst_raw_n),
    .q     (rst_s)
  );

  rbs_pulse_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
    .clk   (clk),
    .arst_n(por_n),
    .rst_s (rst_s),
    .hit   (warm_hit)
  );

  rbs_lock_cnt #(.TICKS(LOCK_TICKS)) u_lock (
    .clk   (clk),
    .arst_n(por_n),
    .run   (in_lock),
    .done  (lock_done)
  );

  rbs_fsm #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_fsm (
    .clk       (clk),
    .arst_n    (por_n),
    .lock_done (lock_done),
    .rst_s     (rst_s),
    .warm_hit  (warm_hit),
    .bus_req   (bus_req),
    .boot_strap(boot_strap),
    .boot_done (boot_done),
    .state_q   (state_q),
    .fetch_addr(fetch_addr)
  );

  assign in_lock = (state_q == ST_LOCK);
  assign in_rst  = in_lock || (state_q == ST_RESET);

  assign core_rst_n   = !in_rst;
  assign stack_rst    = in_rst;
  assign int_mask_all = in_rst;
  assign status_clr   = in_rst;
  assign boot_start   = (state_q == ST_BOOT);
  assign fetch_en     = (state_q == ST_RUN);

  assign ck_en_d = !clkout_dis && !in_lock;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) ck_en_q <= 1'b0;
    else        ck_en_q <= ck_en_d;
  end

  assign clkout_en = ck_en_q;
endmodule

// File: rtl/rbs_seq_chk.sv
module rbs_seq_chk #(
  parameter int LOCK_TICKS = 4000,
  parameter int ADDR_W     = 14
) (
  input logic              clk,
  input logic              por_n,
  input logic              bus_req,
  input logic              boot_strap,
  input logic              clkout_dis,
  input logic              core_rst_n,
  input logic              boot_start,
  input logic              fetch_en,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              clkout_en
);
  logic [31:0] since_por;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                   since_por <= '0;
    else if (since_por != '1)     since_por <= since_por + 1'b1;
  end

  a_r1_lock_window: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n) |-> since_por >= 32'(LOCK_TICKS));

  a_r5_boot_gate: assert property (@(posedge clk) disable iff (!por_n)
    $rose(boot_start) |-> (!$past(bus_req) && $past(boot_strap)));

  a_r6_direct_fetch: assert property (@(posedge clk) disable iff (!por_n)
    $rose(fetch_en) |-> ($past(boot_start) || !$past(boot_strap)));

  a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!por_n)
    (bus_req && !boot_start && !fetch_en) |=> !boot_start);

  a_r8_fetch_zero: assert property (@(posedge clk) disable iff (!por_n)
    fetch_en |-> (fetch_addr == '0));

  a_r9_clkout_off: assert property (@(posedge clk) disable iff (!por_n)
    clkout_dis |=> !clkout_en);
endmodule

bind rst_boot_seq rbs_seq_chk #(
  .LOCK_TICKS(LOCK_IN_CYCLES * CLK_RATIO),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .bus_req   (bus_req),
  .boot_strap(boot_strap),
  .clkout_dis(clkout_dis),
  .core_rst_n(core_rst_n),
  .boot_start(boot_start),
  .fetch_en  (fetch_en),
  .fetch_addr(fetch_addr),
  .clkout_en (clkout_en)
);

// File: tb/rst_boot_seq_bench.sv
`timescale 1ns/1ps
module rst_boot_seq_bench;
  localparam int LOCK_TICKS = 4000;
  localparam int MIN_PULSE  = 8;
  localparam int ADDR_W     = 14;

  logic clk = 1'b0;
  logic por_n, rst_raw_n, bus_req, boot_strap, boot_done, clkout_dis;
  logic core_rst_n, stack_rst, int_mask_all, status_clr;
  logic boot_start, fetch_en, clkout_en;
  logic [ADDR_W-1:0] fetch_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rst_boot_seq u_rst_boot_seq (
    .clk(clk), .por_n(por_n), .rst_raw_n(rst_raw_n), .bus_req(bus_req),
    .boot_strap(boot_strap), .boot_done(boot_done), .clkout_dis(clkout_dis),
    .core_rst_n(core_rst_n), .stack_rst(stack_rst), .int_mask_all(int_mask_all),
    .status_clr(status_clr), .boot_start(boot_start), .fetch_en(fetch_en),
    .fetch_addr(fetch_addr), .clkout_en(clkout_en)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rst_side(input string req, input logic exp);
    chk(req, "stack_rst", stack_rst, exp);
    chk(req, "int_mask_all", int_mask_all, exp);
    chk(req, "status_clr", status_clr, exp);
  endtask

  // R1 R4 R8 R9 then R5/R6 at release
  task automatic t_powerup(input logic strap);
    por_n = 1'b0; rst_raw_n = 1'b1; bus_req = 1'b0; boot_strap = strap;
    boot_done = 1'b0; clkout_dis = 1'b0;
    cyc(3);
    chk("R4", "core_rst_n at por", core_rst_n, 1'b0);
    chk_rst_side("R4", 1'b1);
    chk("R8", "fetch_addr at por", fetch_addr, {ADDR_W{1'b1}});
    chk("R9", "clkout_en at por", clkout_en, 1'b0);
    por_n = 1'b1;
    cyc(LOCK_TICKS - 4);
    chk("R1", "core_rst_n near lock end", core_rst_n, 1'b0);
    chk("R9", "clkout_en in lock", clkout_en, 1'b0);
    cyc(10);
    chk("R1", "core_rst_n after lock", core_rst_n, 1'b1);
    chk_rst_side("R4", 1'b0);
    chk("R9", "clkout_en after lock", clkout_en, 1'b1);
    chk(strap ? "R5" : "R6", "boot_start", boot_start, strap);
    chk(strap ? "R5" : "R6", "fetch_en", fetch_en, !strap);
  endtask

  task automatic t_boot_finish();
    cyc(3);
    chk("R5", "boot_start held", boot_start, 1'b1);
    boot_done = 1'b1;
    cyc(1);
    boot_done = 1'b0;
    chk("R5", "fetch_en after boot_done", fetch_en, 1'b1);
    chk("R5", "boot_start after boot_done", boot_start, 1'b0);
    chk("R8", "fetch_addr in run", fetch_addr, '0);
  endtask

  task automatic t_glitch();
    int bad = 0;
    rst_raw_n = 1'b0;
    cyc(MIN_PULSE - 3);
    rst_raw_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (core_rst_n !== 1'b1 || fetch_en !== 1'b1) bad++;
      cyc(1);
    end
    chk("R3", "cycles disturbed by short dip", bad, 0);
  endtask

  task automatic t_warm(input logic strap);
    int seen_boot = 0;
    boot_strap = strap; bus_req = 1'b0;
    rst_raw_n = 1'b0;
    cyc(MIN_PULSE + 6);
    chk("R2", "core_rst_n in warm reset", core_rst_n, 1'b0);
    chk_rst_side("R4", 1'b1);
    chk("R8", "fetch_addr in warm reset", fetch_addr, {ADDR_W{1'b1}});
    cyc(20);
    chk("R2", "core_rst_n while raw low", core_rst_n, 1'b0);
    rst_raw_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      if (boot_start === 1'b1) seen_boot++;
    end
    chk("R2", "core_rst_n 5 cycles after release", core_rst_n, 1'b1);
    chk("R6", "fetch_en direct", fetch_en, 1'b1);
    chk("R6", "boot_start cycles", seen_boot, 0);
    chk("R8", "fetch_addr direct", fetch_addr, '0);
  endtask

  task automatic t_busreq_hold();
    int bad = 0;
    boot_strap = 1'b0; bus_req = 1'b1;
    rst_raw_n = 1'b0;
    cyc(MIN_PULSE + 6);
    rst_raw_n = 1'b1;
    cyc(5);
    for (int i = 0; i < 10; i++) begin
      if (core_rst_n !== 1'b1 || boot_start !== 1'b0 || fetch_en !== 1'b0) bad++;
      cyc(1);
    end
    chk("R7", "hold cycles wrong", bad, 0);
    boot_strap = 1'b1; bus_req = 1'b0;
    cyc(2);
    chk("R7", "boot_start after request drop", boot_start, 1'b1);
    chk("R7", "fetch_en after request drop", fetch_en, 1'b0);
  endtask

  task automatic t_clkout();
    clkout_dis = 1'b1;
    cyc(2);
    chk("R9", "clkout_en disabled", clkout_en, 1'b0);
    clkout_dis = 1'b0;
    cyc(2);
    chk("R9", "clkout_en re-enabled", clkout_en, 1'b1);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    por_n = 1'b0; rst_raw_n = 1'b1; bus_req = 1'b0; boot_strap = 1'b0;
    boot_done = 1'b0; clkout_dis = 1'b0;
    t_powerup(1'b1);
    t_boot_finish();
    t_glitch();
    t_warm(1'b0);
    t_busreq_hold();
    t_boot_finish();
    t_clkout();
    t_powerup(1'b0);
    cyc(2);
    chk("R8", "fetch_addr after direct power-up", fetch_addr, '0);
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end
endmodule